// File: doc/BRIEF.md
# Key Match-and-Clear Search Engine

This block holds a table of 16-bit records in an internal RAM and, on command, scans a prefix of that table. Any record equal to a search key is overwritten with zero, and every other record keeps its value. Each RAM row packs two records: the even-numbered record sits in bits [15:0] and the odd-numbered record sits in bits [31:16]. Records are numbered from 0 upward, starting at row 0.

The match test uses no magnitude comparator and no per-record branch. Each record is XORed with the key, and that difference is OR-reduced to a single "differs" bit. The record is then ANDed with that bit spread across all 16 bit positions. Both records of a row are handled in parallel. The row is read in one cycle and written back in place in the next, so one row is retired per cycle once the pipeline is full.

A host loads and inspects the table through a simple port while the engine is idle. The host starts a scan with a key and a record count, and waits for a one-cycle done pulse. The number of records that matched is reported on an output that is valid from that pulse onward.

Top module: `keyclr_engine`

## Requirements
- R1: After synchronous active-low reset, busy, done and match_count are all 0.
- R2: For every record index i below the record count, a record equal to the key is left as 0 after the scan, and a record not equal to the key is left unchanged. Record i lives in row i/2, at bits [15:0] when i is even and at bits [31:16] when i is odd.
- R3: Rows at or beyond ceil(count/2) are not modified by a scan.
- R4: When the record count is odd, the upper half (bits [31:16]) of the last scanned row is preserved even if it equals the key. That half is not counted as a match.
- R5: match_count equals the number of records below the count that equal the key. It is valid while done is high and holds its value until the next accepted start.
- R6: Let start be accepted at clock edge E0, and let N = ceil(count/2). Then done is high for exactly one cycle, following edge E(N+1). busy is high from E0 until that edge. A count of 0 gives done after E1.
- R7: A start, key or count applied while busy is high is ignored. The scan in progress uses the key and count sampled at its own accepted start.
- R8: While idle, a host access with host_we=1 writes host_wdata into row host_addr. A host access with host_we=0 returns that row on host_rdata one cycle later. Host writes made while busy are ignored.
- R9: A start presented in the same cycle that done is high is accepted, and it runs a complete new scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a scan (sampled only while idle) |
| key | input | 16 | Search key |
| rec_count | input | 6 | Number of records to scan, 0 to 2*DEPTH |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| match_count | output | 6 | Records cleared by the last scan |
| host_en | input | 1 | Host access request |
| host_we | input | 1 | Host access is a write |
| host_addr | input | 4 | Host row address |
| host_wdata | input | 32 | Host write row |
| host_rdata | output | 32 | Host read row, one cycle after the request |

## Verification
The completion pulse of one scan and the acceptance of the next start can land in the same cycle. The bench provokes this by waiting until it observes done and then driving start with a different key for the following edge. It then judges the result by the second scan's done timing, its match count and the table contents, which must reflect both keys applied in order. Sweeps over every count from 0 to full capacity, with several keys and fill patterns, cover the odd-tail and untouched-row cases around that pairing.

// File: rtl/keyclr_pkg.sv
// Package: shared constants for the key match-and-clear engine.
// Assumes a fixed layout of two 16-bit records per RAM row.
package keyclr_pkg;
    localparam int REC_W = 16;
    localparam int LANES = 2;
    localparam int ROW_W = REC_W * LANES;
endpackage

// File: rtl/keyclr_ram.sv
// Module: keyclr_ram
// Simple two-port RAM, one synchronous read port and one write port.
// Assumes the caller never reads and writes the same row in one cycle.
module keyclr_ram #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Registered read of one row.
    always_ff @(posedge clk) begin
        if (re) rdata <= mem[raddr];
    end

    // Row write.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end
endmodule

// File: rtl/keyclr_lane.sv
// Module: keyclr_lane
// Bitwise match-and-clear of one record: XOR with the key, OR-reduce the
// difference, then AND the record with the replicated "differs" bit.
// A disabled lane passes its record through and reports no hit.
module keyclr_lane #(
    parameter int W = 16
) (
    input  logic [W-1:0] rec,
    input  logic [W-1:0] key,
    input  logic         en,
    output logic [W-1:0] rec_out,
    output logic         hit
);
    logic [W-1:0] diff;
    logic         differs;

    // Compute the cleared record and the hit flag.
    always_comb begin
        diff    = rec ^ key;
        differs = |diff;
        rec_out = en ? (rec & {W{differs}}) : rec;
        hit     = en & ~differs;
    end
endmodule

// File: rtl/keyclr_ctrl.sv
// Module: keyclr_ctrl
// Scan sequencer: accepts start while idle, issues one row read per cycle,
// marks the write-back stage, accumulates hits and pulses done after the
// last write-back. Assumes rec_count does not exceed 2*DEPTH.
module keyclr_ctrl #(
    parameter int DEPTH = 16,
    parameter int REC_W = 16,
    parameter int LANES = 2,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = $clog2(LANES * DEPTH + 1),
    localparam int RCW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [REC_W-1:0] key,
    input  logic [CNT_W-1:0] rec_count,
    input  logic [LANES-1:0] lane_hit,
    output logic [REC_W-1:0] key_q,
    output logic             rd_en,
    output logic [AW-1:0]    rd_addr,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic             upper_en,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] match_count
);
    logic [RCW-1:0]   rd_row;
    logic [RCW-1:0]   rows_q;
    logic             odd_q;
    logic             s1_valid;
    logic [AW-1:0]    s1_row;
    logic             s1_upper_off;
    logic             finish;
    logic [CNT_W-1:0] hit_sum;
    logic [CNT_W:0]   rows_calc;

    // Derive the row count and the per-cycle control decisions.
    always_comb begin
        rows_calc = ({1'b0, rec_count} + 1'b1) >> 1;
        rd_en     = busy && (rd_row != rows_q);
        finish    = busy && (rd_row == rows_q);
        rd_addr   = rd_row[AW-1:0];
        wr_en     = s1_valid;
        wr_addr   = s1_row;
        upper_en  = ~s1_upper_off;
        hit_sum   = '0;
        for (int l = 0; l < LANES; l++) hit_sum = hit_sum + CNT_W'(lane_hit[l]);
    end

    // Sequencer state, pipeline stage and match accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy         <= 1'b0;
            done         <= 1'b0;
            match_count  <= '0;
            key_q        <= '0;
            rows_q       <= '0;
            odd_q        <= 1'b0;
            rd_row       <= '0;
            s1_valid     <= 1'b0;
            s1_row       <= '0;
            s1_upper_off <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy        <= 1'b1;
                    key_q       <= key;
                    rows_q      <= rows_calc[RCW-1:0];
                    odd_q       <= rec_count[0];
                    rd_row      <= '0;
                    match_count <= '0;
                end
            end else begin
                if (s1_valid) match_count <= match_count + hit_sum;
                s1_valid     <= rd_en;
                s1_row       <= rd_row[AW-1:0];
                s1_upper_off <= odd_q && (rd_row == rows_q - 1'b1);
                if (rd_en) rd_row <= rd_row + 1'b1;
                if (finish) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/keyclr_engine.sv
// Module: keyclr_engine (top)
// Key match-and-clear engine: internal record RAM, two parallel bitwise
// lanes and a pipelined sequencer. The host port owns the RAM while idle;
// the sequencer owns it while busy.
module keyclr_engine #(
    parameter int DEPTH = 16,
    localparam int REC_W = keyclr_pkg::REC_W,
    localparam int LANES = keyclr_pkg::LANES,
    localparam int ROW_W = keyclr_pkg::ROW_W,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = $clog2(LANES * DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [REC_W-1:0] key,
    input  logic [CNT_W-1:0] rec_count,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] match_count,
    input  logic             host_en,
    input  logic             host_we,
    input  logic [AW-1:0]    host_addr,
    input  logic [ROW_W-1:0] host_wdata,
    output logic [ROW_W-1:0] host_rdata
);
    logic [REC_W-1:0] key_q;
    logic             eng_rd_en, eng_wr_en, upper_en;
    logic [AW-1:0]    eng_rd_addr, eng_wr_addr;
    logic             ram_re, ram_we;
    logic [AW-1:0]    ram_raddr, ram_waddr;
    logic [ROW_W-1:0] ram_rdata, ram_wdata, eng_wdata;
    logic [LANES-1:0] lane_hit;

    // Arbitrate RAM ports between host and sequencer.
    always_comb begin
        ram_re     = busy ? eng_rd_en   : (host_en && !host_we);
        ram_raddr  = busy ? eng_rd_addr : host_addr;
        ram_we     = busy ? eng_wr_en   : (host_en && host_we);
        ram_waddr  = busy ? eng_wr_addr : host_addr;
        ram_wdata  = busy ? eng_wdata   : host_wdata;
        host_rdata = ram_rdata;
    end

    keyclr_ram #(.DEPTH(DEPTH), .WIDTH(ROW_W)) ram_i (
        .clk(clk), .re(ram_re), .raddr(ram_raddr), .rdata(ram_rdata),
        .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        keyclr_lane #(.W(REC_W)) lane_i (
            .rec    (ram_rdata[l*REC_W +: REC_W]),
            .key    (key_q),
            .en     ((l == LANES - 1) ? upper_en : 1'b1),
            .rec_out(eng_wdata[l*REC_W +: REC_W]),
            .hit    (lane_hit[l])
        );
    end

    keyclr_ctrl #(.DEPTH(DEPTH), .REC_W(REC_W), .LANES(LANES)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start(start), .key(key),
        .rec_count(rec_count), .lane_hit(lane_hit), .key_q(key_q),
        .rd_en(eng_rd_en), .rd_addr(eng_rd_addr), .wr_en(eng_wr_en),
        .wr_addr(eng_wr_addr), .upper_en(upper_en), .busy(busy),
        .done(done), .match_count(match_count)
    );
endmodule

// File: rtl/keyclr_engine_chk.sv
// Module: keyclr_engine_chk
// Protocol checker bound to keyclr_engine; observes ports only.
module keyclr_engine_chk #(
    parameter int CNT_W = 6,
    parameter int MAXC  = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [CNT_W-1:0] match_count
);
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    assert_busy_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    assert_start_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    assert_count_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(match_count));
    assert_count_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        match_count <= CNT_W'(MAXC));
endmodule

bind keyclr_engine keyclr_engine_chk #(.CNT_W(CNT_W), .MAXC(LANES * DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .done(done), .match_count(match_count)
);

// File: tb/keyclr_engine_tb_top.sv
module keyclr_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam int NREC  = 2 * DEPTH;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        start = 0;
    logic [15:0] key = 0;
    logic [5:0]  rec_count = 0;
    logic        busy, done;
    logic [5:0]  match_count;
    logic        host_en = 0, host_we = 0;
    logic [3:0]  host_addr = 0;
    logic [31:0] host_wdata = 0;
    logic [31:0] host_rdata;

    int checks = 0;
    int errors = 0;
    logic [15:0] model [NREC];

    always #(CLK_PERIOD / 2) clk = ~clk;

    keyclr_engine #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .key(key),
        .rec_count(rec_count), .busy(busy), .done(done),
        .match_count(match_count), .host_en(host_en), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input int row, input logic [31:0] d);
        host_en = 1; host_we = 1; host_addr = row[3:0]; host_wdata = d;
        @(negedge clk);
        host_en = 0; host_we = 0;
    endtask

    task automatic host_read(input int row, output logic [31:0] d);
        host_en = 1; host_we = 0; host_addr = row[3:0];
        @(negedge clk);
        host_en = 0;
        d = host_rdata;
    endtask

    task automatic load_model();
        for (int r = 0; r < DEPTH; r++) host_write(r, {model[2*r+1], model[2*r]});
    endtask

    // Apply the clearing rule to the model and return the expected match count.
    function automatic int apply_model(input logic [15:0] k, input int c);
        int m = 0;
        for (int i = 0; i < c; i++)
            if (model[i] == k) begin model[i] = 16'h0; m++; end
        return m;
    endfunction

    // Start a scan and return the negedge index at which done is seen.
    task automatic run_scan(input logic [15:0] k, input int c, output int cyc);
        start = 1; key = k; rec_count = c[5:0];
        @(negedge clk);
        start = 0;
        cyc = 0;
        while (!done && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic verify_table(input string req);
        logic [31:0] d;
        for (int r = 0; r < DEPTH; r++) begin
            host_read(r, d);
            check(req, d, {model[2*r+1], model[2*r]});
        end
    endtask

    task automatic sweep(input int pat, input logic [15:0] k);
        int cyc, expm;
        for (int c = 0; c <= NREC; c++) begin
            for (int i = 0; i < NREC; i++) begin
                case (pat)
                    0: model[i] = (i % 3 == 0) ? k : 16'(k ^ (16'h0101 * (i + 1)));
                    1: model[i] = k;
                    default: model[i] = (i % 2 == 1) ? k : 16'(k + 16'(i) + 1);
                endcase
            end
            load_model();
            expm = apply_model(k, c);
            run_scan(k, c, cyc);
            // R6: done seen after edge E(N+1); R4 and R3 covered by table compare.
            check("R6 done latency", cyc, (c + 1) / 2 + 1);
            check("R5 match_count", {26'd0, match_count}, expm);
            @(negedge clk);
            check("R6 done single pulse", {31'd0, done}, 0);
            check("R5 match_count held", {26'd0, match_count}, expm);
            verify_table("R2 R3 R4 table contents");
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int cyc, m1, m2;
        logic [31:0] d;
        repeat (3) @(negedge clk);
        check("R1 busy after reset", {31'd0, busy}, 0);
        check("R1 done after reset", {31'd0, done}, 0);
        check("R1 match_count after reset", {26'd0, match_count}, 0);
        rst_n = 1;
        @(negedge clk);

        // R8: host write/read round trip while idle.
        host_write(5, 32'hDEAD_BEEF);
        host_read(5, d);
        check("R8 host readback", d, 32'hDEAD_BEEF);

        sweep(0, 16'h1234);
        sweep(1, 16'h0000);
        sweep(1, 16'hFFFF);
        sweep(2, 16'hA5C3);

        // R7: start/key changes during a run and host write while busy are ignored.
        for (int i = 0; i < NREC; i++) model[i] = (i % 4 == 0) ? 16'h7777 : 16'h8888;
        load_model();
        m1 = apply_model(16'h7777, 20);
        start = 1; key = 16'h7777; rec_count = 6'd20;
        @(negedge clk);
        start = 0;
        @(negedge clk);
        start = 1; key = 16'h8888; rec_count = 6'd32;
        host_en = 1; host_we = 1; host_addr = 4'd15; host_wdata = 32'h0;
        @(negedge clk);
        start = 0; host_en = 0; host_we = 0;
        cyc = 2;
        while (!done && cyc < 200) begin @(negedge clk); cyc++; end
        check("R7 done latency unchanged", cyc, 11);
        check("R7 match_count uses first key", {26'd0, match_count}, m1);
        @(negedge clk);
        verify_table("R7 R8 table after ignored inputs");

        // R9: start in the same cycle as done.
        for (int i = 0; i < NREC; i++) model[i] = (i % 2 == 0) ? 16'h1111 : 16'h2222;
        load_model();
        m1 = apply_model(16'h1111, 9);
        run_scan(16'h1111, 9, cyc);
        check("R9 first done latency", cyc, 6);
        check("R9 first match_count", {26'd0, match_count}, m1);
        m2 = apply_model(16'h2222, 32);
        run_scan(16'h2222, 32, cyc);
        check("R9 second done latency", cyc, 17);
        check("R9 second match_count", {26'd0, match_count}, m2);
        @(negedge clk);
        verify_table("R9 table after back-to-back scans");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule